// File: doc/BRIEF.md
# ADC Interrupt Flag Controller

This block takes the end-of-conversion strobes of an ADC and decides, for one interrupt line, when a pulse goes on to the interrupt expander. A sticky pending flag records that a conversion finished and software has not yet serviced it. A separate overrun bit records that another conversion finished while the flag was still pending. While the overrun bit is set, a single flag clear does not re-arm the line. Recovery takes three writes in order: flag clear, overrun clear, then a second flag clear. A continuous-mode bit lets every selected event through as a pulse, whatever the flag state.

The behaviour is held in a three-state machine.

States:
- **ARMED**: flag clear, overrun clear.
- **PENDING**: flag set, overrun clear.
- **OVERRUN**: flag set, overrun set.

Transitions:
- **fire**: ARMED to PENDING when a selected event arrives. This emits a pulse.
- **service**: PENDING to ARMED when there is a flag clear and no event in the same cycle.
- **overrun**: PENDING to OVERRUN when there is an event and no flag clear in the same cycle.
- **acknowledge**: OVERRUN to PENDING when there is an overrun clear and no event in the same cycle.
- **hold**: every other case keeps the current state.

Software reaches the block through a synchronous register port. Each write takes one cycle. Reads are combinational.

| Address | Name | Access | Contents |
|---|---|---|---|
| 0 | configuration | read/write | bit 0 enable, bit 1 continuous, bits 6:2 source select |
| 1 | flag clear | write-one-to-clear | bit 0 |
| 2 | overrun clear | write-one-to-clear | bit 0 |
| 3 | status | read-only | bit 1 overrun, bit 0 flag |

Top module: `adcirq_flag_ctrl`

## Requirements
- R1: After reset the flag, overrun, enable, continuous and select fields are all 0, `irq_o` is low, and reads of addresses 0 and 3 return 0.
- R2: A selected event while the flag is clear sets the flag. `irq_o` is high for exactly the one cycle after the event edge, and the flag reads 1 from then on.
- R3: In non-continuous mode, a selected event while the flag is set produces no pulse and sets the overrun bit. Status reads 2'b11.
- R4: A write to address 1 with bit 0 = 1 clears the flag when overrun is clear. The same write with bit 0 = 0 leaves the flag set.
- R5: While overrun is set, a flag clear has no effect. After an overrun clear, a second flag clear returns status to 2'b00. The overrun bit is never set while the flag is clear.
- R6: When a flag clear and a selected event fall in the same cycle, the event wins. The flag stays set, overrun is not set, and no pulse is produced.
- R7: With the continuous bit (address 0 bit 1) set, every selected event produces a pulse on the next cycle, whether or not the flag is set. Flag and overrun are tracked as in R2 and R3.
- R8: Only the input indexed by the source select (address 0 bits 6:2) is captured. A select value of 16 or more captures nothing.
- R9: With the enable bit (address 0 bit 0) clear, events change neither the flag nor the overrun bit, and produce no pulse.
- R10: A write to address 2 with bit 0 = 1 clears overrun and never changes the flag. When an event arrives in the same cycle as an overrun clear while the flag is set, overrun ends up set.
- R11: Address 0 reads back the last configuration written in bits 6:0. Address 3 returns {overrun, flag} in bits 1:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eoc_i | input | NUM_SRC | End-of-conversion strobes, one per source |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | DATA_W | Register write data |
| rdata_o | output | DATA_W | Register read data, combinational from `addr_i` |
| irq_o | output | 1 | Single-cycle interrupt pulse to the expander |

## Verification
The assertions check, on every cycle:
- that a pulse follows each event that fires from ARMED, and that a non-continuous pulse never lasts two cycles;
- that a flag clear is blocked while overrun is set, and that overrun never stands without the flag;
- that a same-cycle clear loses to an event, and that the line is silent while disabled.

Some behaviours can only be shown by the bench's scenarios, which read status back over the port:
- the full three-write recovery out of OVERRUN;
- source selection across indices, including out-of-range select values;
- configuration readback;
- that a clear write with bit 0 low changes nothing.

// File: rtl/adcirq_pkg.sv
package adcirq_pkg;

    localparam int REG_ADDR_W = 2;
    localparam int SRC_SEL_W  = 5;

    localparam logic [REG_ADDR_W-1:0] ADDR_CFG      = 2'd0;
    localparam logic [REG_ADDR_W-1:0] ADDR_FLAG_CLR = 2'd1;
    localparam logic [REG_ADDR_W-1:0] ADDR_OVF_CLR  = 2'd2;
    localparam logic [REG_ADDR_W-1:0] ADDR_STATUS   = 2'd3;

    // flag = bit 0 of the encoding, overrun = bit 1
    typedef enum logic [1:0] {
        ST_ARMED   = 2'b00,
        ST_PENDING = 2'b01,
        ST_OVERRUN = 2'b11
    } irq_state_e;

    typedef struct packed {
        logic [SRC_SEL_W-1:0] src_sel;   // bits 6:2
        logic                 cont;      // bit 1
        logic                 en;        // bit 0
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

endpackage

// File: rtl/adcirq_src_sel.sv
module adcirq_src_sel #(
    parameter int NUM_SRC = 16,
    parameter int SEL_W   = 5
) (
    input  logic [NUM_SRC-1:0] eoc,
    input  logic [SEL_W-1:0]   sel,
    input  logic               en,
    output logic               hit
);
    logic [NUM_SRC-1:0] match;

    genvar g;
    generate
        for (g = 0; g < NUM_SRC; g++) begin : g_src
            assign match[g] = (sel == SEL_W'(g)) && eoc[g];
        end
    endgenerate

    // out-of-range select values match no lane
    assign hit = en && (|match);
endmodule

// File: rtl/adcirq_fsm.sv
module adcirq_fsm
    import adcirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic flag_clr,
    input  logic ovf_clr,
    input  logic cont,
    output logic flag,
    output logic ovf,
    output logic irq
);
    irq_state_e state_q, state_d;
    logic       irq_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARMED: begin
                if (evt) state_d = ST_PENDING;                      // fire
            end
            ST_PENDING: begin
                if (evt && !flag_clr)      state_d = ST_OVERRUN;    // overrun
                else if (flag_clr && !evt) state_d = ST_ARMED;      // service
            end
            ST_OVERRUN: begin
                if (ovf_clr && !evt) state_d = ST_PENDING;          // acknowledge
            end
            default: state_d = ST_ARMED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_ARMED;
        else        state_q <= state_d;
    end

    always_comb begin
        irq_d = evt && (cont || (state_q == ST_ARMED));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= irq_d;
    end

    assign flag = (state_q != ST_ARMED);
    assign ovf  = (state_q == ST_OVERRUN);
endmodule

// File: rtl/adcirq_regs.sv
module adcirq_regs
    import adcirq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [REG_ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0]     wdata,
    input  logic                  flag,
    input  logic                  ovf,
    output cfg_t                  cfg,
    output logic                  flag_clr,
    output logic                  ovf_clr,
    output logic [DATA_W-1:0]     rdata
);
    always_ff @(posedge clk) begin
        if (!rst_n)                          cfg <= '0;
        else if (wr_en && addr == ADDR_CFG)  cfg <= cfg_t'(wdata[CFG_W-1:0]);
    end

    assign flag_clr = wr_en && (addr == ADDR_FLAG_CLR) && wdata[0];
    assign ovf_clr  = wr_en && (addr == ADDR_OVF_CLR)  && wdata[0];

    always_comb begin
        rdata = '0;
        unique case (addr)
            ADDR_CFG:    rdata[CFG_W-1:0] = cfg;
            ADDR_STATUS: rdata[1:0]       = {ovf, flag};
            default:     rdata            = '0;
        endcase
    end
endmodule

// File: rtl/adcirq_flag_ctrl.sv
module adcirq_flag_ctrl
    import adcirq_pkg::*;
#(
    parameter int NUM_SRC = 16,
    parameter int DATA_W  = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_SRC-1:0]    eoc_i,
    input  logic                  wr_en_i,
    input  logic [REG_ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0]     wdata_i,
    output logic [DATA_W-1:0]     rdata_o,
    output logic                  irq_o
);
    cfg_t cfg_q;
    logic evt_hit;
    logic flag_clr_stb;
    logic ovf_clr_stb;
    logic flag_st;
    logic ovf_st;

    adcirq_regs #(.DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en_i),
        .addr     (addr_i),
        .wdata    (wdata_i),
        .flag     (flag_st),
        .ovf      (ovf_st),
        .cfg      (cfg_q),
        .flag_clr (flag_clr_stb),
        .ovf_clr  (ovf_clr_stb),
        .rdata    (rdata_o)
    );

    adcirq_src_sel #(.NUM_SRC(NUM_SRC), .SEL_W(SRC_SEL_W)) u_sel (
        .eoc (eoc_i),
        .sel (cfg_q.src_sel),
        .en  (cfg_q.en),
        .hit (evt_hit)
    );

    adcirq_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt_hit),
        .flag_clr (flag_clr_stb),
        .ovf_clr  (ovf_clr_stb),
        .cont     (cfg_q.cont),
        .flag     (flag_st),
        .ovf      (ovf_st),
        .irq      (irq_o)
    );
endmodule

// File: rtl/adcirq_checker.sv
module adcirq_checker (
    input logic clk,
    input logic rst_n,
    input logic ev,
    input logic flag_clr,
    input logic ovf_clr,
    input logic cont,
    input logic en,
    input logic flag,
    input logic ovf,
    input logic irq
);
    assert_pulse_on_arm_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ev && !flag) |=> (flag && irq));

    assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cont && irq) |=> !irq);

    assert_no_pulse_overrun_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cont && ev && flag && !flag_clr) |=> (ovf && !irq));

    assert_clear_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && flag_clr) |=> flag);

    assert_ovf_needs_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> flag);

    assert_event_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cont && ev && flag && !ovf && flag_clr) |=> (flag && !ovf && !irq));

    assert_cont_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cont && ev) |=> irq);

    assert_disabled_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !irq);

    assert_ovf_clr_keeps_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_clr && flag && !ev) |=> (flag && !ovf));
endmodule

bind adcirq_flag_ctrl adcirq_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev       (evt_hit),
    .flag_clr (flag_clr_stb),
    .ovf_clr  (ovf_clr_stb),
    .cont     (cfg_q.cont),
    .en       (cfg_q.en),
    .flag     (flag_st),
    .ovf      (ovf_st),
    .irq      (irq_o)
);

// File: tb/adcirq_flag_ctrl_bench.sv
module adcirq_flag_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NSRC = 16;
    localparam int DW   = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] eoc = '0;
    logic            wr_en = 1'b0;
    logic [1:0]      addr = 2'd0;
    logic [DW-1:0]   wdata = '0;
    logic [DW-1:0]   rdata;
    logic            irq;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    // behavioural reference state
    int m_flag = 0, m_ovf = 0, m_irq = 0, m_en = 0, m_cont = 0, m_sel = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adcirq_flag_ctrl #(.NUM_SRC(NSRC), .DATA_W(DW)) u_adcirq_flag_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .eoc_i   (eoc),
        .wr_en_i (wr_en),
        .addr_i  (addr),
        .wdata_i (wdata),
        .rdata_o (rdata),
        .irq_o   (irq)
    );

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_flag = 0; m_ovf = 0; m_irq = 0; m_en = 0; m_cont = 0; m_sel = 0;
        end else begin
            int ev, fc, oc;
            ev = (m_en != 0 && m_sel < NSRC) ? int'(eoc[m_sel % NSRC]) : 0;
            fc = (wr_en && addr == 2'd1 && wdata[0]) ? 1 : 0;
            oc = (wr_en && addr == 2'd2 && wdata[0]) ? 1 : 0;
            m_irq = (ev != 0 && (m_cont != 0 || m_flag == 0)) ? 1 : 0;
            if (ev != 0 && m_flag != 0 && fc == 0) m_ovf = 1;
            else if (oc != 0)                      m_ovf = 0;
            if (ev != 0)                       m_flag = 1;
            else if (fc != 0 && m_ovf == 0 && !(oc != 0)) m_flag = 0;
            else if (fc != 0 && m_ovf == 0)    m_flag = 0;
            if (wr_en && addr == 2'd0) begin
                m_en = int'(wdata[0]); m_cont = int'(wdata[1]); m_sel = int'(wdata[6:2]);
            end
        end
    end

    // per-clock comparison of the pulse output against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (int'(irq) != m_irq) begin
                fails++;
                $display("FAIL R2/R3/R7 per-cycle irq: actual %0d expected %0d at cycle %0d",
                         irq, m_irq, cycles);
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [DW-1:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0; wdata = '0;
    endtask

    task automatic reg_rd(input logic [1:0] a, input int exp, input string tag);
        @(negedge clk); wr_en = 1'b0; addr = a;
        #1;
        check(tag, int'(rdata), exp);
    endtask

    task automatic pulse(input logic [NSRC-1:0] m, input int exp_irq, input string tag);
        @(negedge clk); eoc = m;
        @(negedge clk); eoc = '0;
        check(tag, int'(irq), exp_irq);
    endtask

    task automatic pulse_wr(input logic [NSRC-1:0] m, input logic [1:0] a,
                            input logic [DW-1:0] d, input int exp_irq, input string tag);
        @(negedge clk); eoc = m; wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); eoc = '0; wr_en = 1'b0; wdata = '0;
        check(tag, int'(irq), exp_irq);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 irq after reset", int'(irq), 0);
        reg_rd(2'd3, 0, "R1 status after reset");
        reg_rd(2'd0, 0, "R1 config after reset");

        reg_wr(2'd0, 8'h0D);                 // enable, select 3
        reg_rd(2'd0, 8'h0D, "R11 config readback");
        pulse(16'h0008, 1, "R2 pulse on first event");
        reg_rd(2'd3, 1, "R2 flag set");
        pulse(16'h0020, 0, "R8 unselected input");
        reg_rd(2'd3, 1, "R8 status unchanged");
        pulse(16'h0008, 0, "R3 no pulse while pending");
        reg_rd(2'd3, 3, "R3 overrun set");
        reg_wr(2'd1, 8'h01);
        reg_rd(2'd3, 3, "R5 flag clear blocked by overrun");
        reg_wr(2'd2, 8'h01);
        reg_rd(2'd3, 1, "R10 overrun clear keeps flag");
        reg_wr(2'd1, 8'h01);
        reg_rd(2'd3, 0, "R5 second clear re-arms");

        pulse(16'h0008, 1, "R2 pulse after re-arm");
        reg_wr(2'd1, 8'h00);
        reg_rd(2'd3, 1, "R4 clear with bit0 low ignored");
        reg_wr(2'd1, 8'h01);
        reg_rd(2'd3, 0, "R4 clear with bit0 high");

        pulse(16'h0008, 1, "R2 pulse before race");
        pulse_wr(16'h0008, 2'd1, 8'h01, 0, "R6 race gives no pulse");
        reg_rd(2'd3, 1, "R6 event wins, no overrun");
        pulse_wr(16'h0008, 2'd2, 8'h01, 0, "R10 race with overrun clear");
        reg_rd(2'd3, 3, "R10 overrun set wins");
        reg_wr(2'd2, 8'h01);
        reg_wr(2'd1, 8'h01);
        reg_rd(2'd3, 0, "R5 recovery sequence");

        reg_wr(2'd0, 8'h0F);                 // continuous, enable, select 3
        for (int i = 0; i < 3; i++) pulse(16'h0008, 1, "R7 continuous pulse");
        reg_rd(2'd3, 3, "R7 flags still tracked");
        reg_wr(2'd2, 8'h01);
        reg_wr(2'd1, 8'h01);

        reg_wr(2'd0, 8'h0C);                 // disabled, select 3
        pulse(16'h0008, 0, "R9 disabled no pulse");
        reg_rd(2'd3, 0, "R9 disabled no flag");

        reg_wr(2'd0, 8'h41);                 // enable, select 16
        reg_rd(2'd0, 8'h41, "R11 out-of-range select readback");
        pulse(16'hFFFF, 0, "R8 select 16 captures nothing");
        reg_rd(2'd3, 0, "R8 select 16 status");

        reg_wr(2'd0, 8'h3D);                 // enable, select 15
        pulse(16'h7FFF, 0, "R8 other lanes ignored");
        pulse(16'h8000, 1, "R8 select 15 pulse");
        reg_rd(2'd3, 1, "R8 select 15 flag");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        wait (cycles > 5000);
        if (!done) begin
            done = 1'b1;
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end
endmodule